// File: doc/BRIEF.md
# Eight-Port Parallel I/O Controller

This block lets a host processor run eight byte-wide parallel ports through a small register window. The host addresses it with an offset, a read strobe, a write strobe and byte-wide data. Each port has a byte of data held for output and one bit in a direction register. When a port is set as an input, a read of it returns whatever is present on its input bus. When it is set as an output, the port drives its held byte and a read returns that same byte.

The window holds three more registers. A control register drives three single-bit pins from its low bits. A direction register selects input or output for each port. A fixed four-byte signature lets software identify the part. Both the control and direction registers appear at two offsets each, and only the higher offset of each pair accepts writes.

The held byte is updated on every port write, including writes to ports set as inputs. It reaches the output bus when the port becomes an output. A port set as an input drives zero on its output bus and raises no output enable. Tri-state pads are not part of the block; external buffers use the per-port enable instead.

Top module: `parallel_io_ctrl`

## Requirements
- R1: Only the low four bits of `bus_addr` are decoded. Any value of the upper address bits reaches the same register as the same low nibble.
- R2: A read at offset n (0 to 7) while direction bit n is 0 returns the current byte on input bus n, which is `port_in[8n+7:8n]`.
- R3: A read at offset n (0 to 7) while direction bit n is 1 returns the byte held for port n.
- R4: A write at offset n (0 to 7) always replaces the byte held for port n. Output bus n shows the new byte from the following cycle only if direction bit n is 1; otherwise the output bus stays at 0x00.
- R5: Reads at offsets 0x8, 0x9, 0xA and 0xB return the constant bytes 0x53, 0x45, 0x47 and 0x41 respectively.
- R6: The control register is read at both 0xC and 0xE and is written only at 0xE. All eight bits are read back as written, and bits 2..0 drive `ctrl_out[2:0]` from the cycle after the write.
- R7: The direction register is read at both 0xD and 0xF and is written only at 0xF. Bit n = 1 makes port n an output, and `port_oe[n]` equals bit n from the cycle after the write.
- R8: In the cycle after a direction write turns port n into an output, output bus n carries the byte held for port n. In the cycle after a direction write turns port n back into an input, output bus n is 0x00.
- R9: A synchronous, active-high `rst` sets every direction bit to 0 and clears all eight held bytes and the control register. It also drives every output bus, every `port_oe` bit and all `ctrl_out` pins to 0.
- R10: Writes at offsets 0x8 to 0xD change no held byte, no direction bit and no control bit.
- R11: Whenever `bus_rd` is low, `bus_rdata` is 0x00. Read data is combinational from the current address and register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | HOST_ADDR_W | Host offset; only bits 3..0 are decoded |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| port_in | input | 64 | Input buses; port n uses bits 8n+7..8n |
| port_out | output | 64 | Output buses; port n uses bits 8n+7..8n |
| port_oe | output | 8 | Output enable per port, equal to its direction bit |
| ctrl_out | output | 3 | Control pins from control register bits 2..0 |

## Verification
The bench builds the block with `HOST_ADDR_W` set to 6. The two extra address bits let it reach every register through aliases whose upper bits are non-zero, which confirms that those bits are ignored. It changes direction while the held bytes differ from the input buses, so every bench check can tell a held byte from live input, and both from zero, on reads and on the output buses. A reset in the middle of the run, followed by turning all ports into outputs, exposes any held byte that survived the reset.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int NPORT   = 8;
    localparam int BYTE_W  = 8;
    localparam int NCTRL   = 3;
    localparam int IDX_W   = $clog2(NPORT);
    localparam int NIB_W   = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        RG_PORT = 2'd0,
        RG_ID   = 2'd1,
        RG_CTRL = 2'd2,
        RG_DIR  = 2'd3
    } region_e;

    typedef struct packed {
        region_e          region;
        logic [IDX_W-1:0] idx;
        logic             wr_ok;
    } dec_t;

    typedef struct packed {
        logic [NPORT-1:0][BYTE_W-1:0] latch;
        logic [NPORT-1:0]             dir;
        byte_t                        ctrl;
    } regs_t;

    // Signature bytes, first byte at the lowest identification offset.
    localparam logic [4*BYTE_W-1:0] ID_WORD = 32'h5345_4741;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output dec_t             dec
);
    always_comb begin
        dec = '0;
        unique case (nib[3:2])
            2'b00, 2'b01: begin
                dec.region = RG_PORT;
                dec.idx    = nib[2:0];
                dec.wr_ok  = 1'b1;
            end
            2'b10: begin
                dec.region = RG_ID;
                dec.idx    = {1'b0, nib[1:0]};
                dec.wr_ok  = 1'b0;
            end
            default: begin
                // low bit picks direction vs control; bit 1 marks the writable alias
                dec.region = nib[0] ? RG_DIR : RG_CTRL;
                dec.idx    = '0;
                dec.wr_ok  = nib[1];
            end
        endcase
    end
endmodule

// File: rtl/pio_id_rom.sv
module pio_id_rom
    import pio_pkg::*;
(
    input  logic [1:0] sel,
    output byte_t      id_byte
);
    always_comb begin
        id_byte = ID_WORD[(3 - sel) * BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/pio_port_slice.sv
module pio_port_slice
    import pio_pkg::*;
(
    input  byte_t latch,
    input  logic  is_out,
    input  byte_t pin_in,
    output byte_t pin_out,
    output byte_t rd_val
);
    always_comb begin
        pin_out = is_out ? latch : '0;
        rd_val  = is_out ? latch : pin_in;
    end
endmodule

// File: rtl/parallel_io_ctrl.sv
module parallel_io_ctrl
    import pio_pkg::*;
#(
    parameter int HOST_ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [HOST_ADDR_W-1:0]   bus_addr,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    input  logic [NPORT*BYTE_W-1:0]  port_in,
    output logic [NPORT*BYTE_W-1:0]  port_out,
    output logic [NPORT-1:0]         port_oe,
    output logic [NCTRL-1:0]         ctrl_out
);
    regs_t r_d, r_q;
    dec_t  dec;
    byte_t id_byte;
    byte_t rd_val;
    logic [NPORT-1:0][BYTE_W-1:0] port_rd;

    pio_decode u_dec (
        .nib (bus_addr[NIB_W-1:0]),
        .dec (dec)
    );

    pio_id_rom u_id (
        .sel     (dec.idx[1:0]),
        .id_byte (id_byte)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        pio_port_slice u_slice (
            .latch   (r_q.latch[g]),
            .is_out  (r_q.dir[g]),
            .pin_in  (port_in[g*BYTE_W +: BYTE_W]),
            .pin_out (port_out[g*BYTE_W +: BYTE_W]),
            .rd_val  (port_rd[g])
        );
    end

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            unique case (dec.region)
                RG_PORT: r_d.latch[dec.idx] = bus_wdata;
                RG_CTRL: if (dec.wr_ok) r_d.ctrl = bus_wdata;
                RG_DIR:  if (dec.wr_ok) r_d.dir  = bus_wdata[NPORT-1:0];
                default: ;
            endcase
        end
        if (rst) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    always_comb begin
        unique case (dec.region)
            RG_PORT: rd_val = port_rd[dec.idx];
            RG_ID:   rd_val = id_byte;
            RG_CTRL: rd_val = r_q.ctrl;
            default: rd_val = byte_t'(r_q.dir);
        endcase
        bus_rdata = bus_rd ? rd_val : '0;
    end

    assign port_oe  = r_q.dir;
    assign ctrl_out = r_q.ctrl[NCTRL-1:0];
endmodule

// File: rtl/parallel_io_ctrl_chk.sv
module parallel_io_ctrl_chk
    import pio_pkg::*;
#(
    parameter int HOST_ADDR_W = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic [HOST_ADDR_W-1:0]  bus_addr,
    input logic                    bus_rd,
    input logic                    bus_wr,
    input logic [BYTE_W-1:0]       bus_wdata,
    input logic [BYTE_W-1:0]       bus_rdata,
    input logic [NPORT*BYTE_W-1:0] port_out,
    input logic [NPORT-1:0]        port_oe,
    input logic [NCTRL-1:0]        ctrl_out
);
    logic [3:0] nib;
    assign nib = bus_addr[3:0];

    assert_reset_clear_R9: assert property (@(posedge clk)
        $fell(rst) |-> (port_out == '0 && port_oe == '0 && ctrl_out == '0));

    assert_input_port_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !nib[3] && !port_oe[nib[2:0]]) |=> $stable(port_out));

    assert_ignored_write_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && nib >= 4'h8 && nib <= 4'hD) |=>
        ($stable(port_out) && $stable(port_oe) && $stable(ctrl_out)));

    assert_dir_write_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && nib == 4'hF) |=> port_oe == $past(bus_wdata[NPORT-1:0]));

    assert_ctrl_write_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && nib == 4'hE) |=> ctrl_out == $past(bus_wdata[NCTRL-1:0]));

    assert_id_first_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && nib == 4'h8) |-> bus_rdata == 8'h53);

    assert_idle_read_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == '0);
endmodule

bind parallel_io_ctrl parallel_io_ctrl_chk #(.HOST_ADDR_W(HOST_ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .port_out  (port_out),
    .port_oe   (port_oe),
    .ctrl_out  (ctrl_out)
);

// File: tb/tb_parallel_io_ctrl.sv
module tb_parallel_io_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [63:0]   port_in = '0;
    logic [63:0]   port_out;
    logic [7:0]    port_oe;
    logic [2:0]    ctrl_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] m_latch [8];
    logic [7:0] m_dir;
    logic [7:0] m_ctrl;

    parallel_io_ctrl #(.HOST_ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_in(port_in),
        .port_out(port_out), .port_oe(port_oe), .ctrl_out(ctrl_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model, updated on the same edge as the design
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) m_latch[i] = 8'h00;
            m_dir  = 8'h00;
            m_ctrl = 8'h00;
        end else if (bus_wr) begin
            if (bus_addr[3:0] < 4'h8) m_latch[bus_addr[2:0]] = bus_wdata;
            else if (bus_addr[3:0] == 4'hE) m_ctrl = bus_wdata;
            else if (bus_addr[3:0] == 4'hF) m_dir = bus_wdata;
        end
    end

    function automatic logic [7:0] exp_read(input logic [3:0] n);
        if (n < 4'h8) return m_dir[n[2:0]] ? m_latch[n[2:0]] : port_in[n[2:0]*8 +: 8];
        case (n)
            4'h8: return 8'h53;
            4'h9: return 8'h45;
            4'hA: return 8'h47;
            4'hB: return 8'h41;
            4'hC, 4'hE: return m_ctrl;
            default: return m_dir;
        endcase
    endfunction

    function automatic logic [63:0] exp_out();
        logic [63:0] v = '0;
        for (int i = 0; i < 8; i++) if (m_dir[i]) v[i*8 +: 8] = m_latch[i];
        return v;
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare outputs against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && cycles > 2) begin
            check(port_out, exp_out(), "R8 port_out vs model");
            check({56'd0, port_oe}, {56'd0, m_dir}, "R7 port_oe vs model");
            check({61'd0, ctrl_out}, {61'd0, m_ctrl[2:0]}, "R6 ctrl_out vs model");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check({56'd0, bus_rdata}, {56'd0, exp_read(a[3:0])}, tag);
        bus_rd = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) port_in[i*8 +: 8] = 8'(i * 8'h11 + 8'h03);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(port_out, 64'd0, "R9 port_out after reset");
        check({56'd0, port_oe}, 64'd0, "R9 port_oe after reset");
        check({61'd0, ctrl_out}, 64'd0, "R9 ctrl_out after reset");
        rd(6'h0C, "R9 ctrl reads 0 after reset");
        rd(6'h0D, "R9 dir reads 0 after reset");

        for (int i = 0; i < 8; i++) rd(AW'(i), "R2 input port read");
        for (int i = 8; i < 12; i++) rd(AW'(i), "R5 signature byte");
        rd(6'h39, "R1 mirrored signature read");
        rd(6'h22, "R1 mirrored input read");

        for (int i = 0; i < 8; i++) wr(AW'(i), 8'(8'hA0 + i));
        check(port_out, 64'd0, "R4 input ports keep 0 after latch write");
        rd(6'h03, "R2 input read unaffected by latch");

        wr(6'h0F, 8'hA5);
        check(port_out[7:0], 64'hA0, "R8 port 0 shows latch");
        check(port_out[15:8], 64'h00, "R8 port 1 stays 0");
        for (int i = 0; i < 8; i++) rd(AW'(i), "R3 output-mode read");
        rd(6'h0D, "R7 dir read alias");

        wr(6'h00, 8'h5C);
        check(port_out[7:0], 64'h5C, "R4 output port updates");
        wr(6'h01, 8'h77);
        check(port_out[15:8], 64'h00, "R4 input port unchanged");

        wr(6'h0C, 8'hFF);
        rd(6'h0E, "R6 write at 0xC ignored");
        wr(6'h0E, 8'hDE);
        check({61'd0, ctrl_out}, 64'h6, "R6 ctrl pins");
        rd(6'h0C, "R6 full byte read back");

        wr(6'h0D, 8'h00);
        check({56'd0, port_oe}, 64'hA5, "R10 write at 0xD ignored");
        for (int i = 8; i < 12; i++) wr(AW'(i), 8'hFF);
        rd(6'h0A, "R10 signature unchanged");
        check(port_out, exp_out(), "R10 outputs unchanged");

        wr(6'h0F, 8'h5A);
        check(port_out[7:0], 64'h00, "R8 port 0 back to input is 0");
        check(port_out[15:8], 64'h77, "R8 port 1 shows stored latch");

        wr(6'h2F, 8'hFF);
        check({56'd0, port_oe}, 64'hFF, "R1 mirrored dir write");
        rd(6'h35, "R1 mirrored port read");

        @(negedge clk);
        bus_addr = 6'h08; #1;
        check({56'd0, bus_rdata}, 64'd0, "R11 idle read data");

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(port_out, 64'd0, "R9 outputs after mid-run reset");
        check({61'd0, ctrl_out}, 64'd0, "R9 ctrl after mid-run reset");
        wr(6'h0F, 8'hFF);
        check(port_out, 64'd0, "R9 latches cleared by reset");

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule